// File: doc/BRIEF.md
# I2C Target Byte Buffer

This block sits between the byte-level engine of an I2C target and the register or DMA side of the chip. It holds two two-stage byte paths. On the outgoing path, a holding register that software fills sits in front of a shift stage that the engine takes bytes from. On the incoming path, a shift stage that the engine fills sits in front of a holding register that software reads. It also latches the matched address byte, raises the transmit-request, receive-ready and address-valid flags, and records a sticky overrun.

A transfer becomes a target-transmit transfer or a target-receive transfer when an address matches, depending on bit 0 of that address byte. A STOP returns the tracker to idle. Two settings shape the block's behaviour. The address-routing bit decides whether the matched address is also passed through the receive path, so that a DMA channel can collect it in sequence with the data. The request-mode bit decides whether the transmit request depends only on an empty holding register, or also needs a detected target-transmit transfer.

Top module: `i2ct_data_buffer`

## Requirements
- R1: While and directly after reset, flag_rx, flag_addr, err_ovf and tx_byte_valid are 0, and flag_tx equals cfg_tx_on_empty.
- R2: With cfg_addr_to_rx=0, an ev_addr_match pulse loads addr_status with ev_addr_byte and sets flag_addr on the next edge. A rd_addr pulse while flag_addr is 1 clears it.
- R3: With cfg_addr_to_rx=1, the matched byte also enters the receive shift stage, tagged as an address. Once it reaches the holding register (two edges after the match), flag_addr is 1, rx_data shows the address and flag_rx stays 0. A rd_rx pulse, or a rd_addr pulse, removes it and clears flag_addr.
- R4: Bit 0 of the matched address byte selects the direction: 1 means target-transmit and 0 means target-receive. With cfg_tx_on_empty=1, flag_tx is 1 whenever the transmit holding register is empty. With cfg_tx_on_empty=0, flag_tx is also held at 0 unless a target-transmit transfer is active.
- R5: A wr_tx pulse while flag_tx is 1 loads wr_data into the holding register, and flag_tx reads 0 after that edge. A wr_tx pulse while flag_tx is 0 is ignored and leaves the holding register unchanged.
- R6: A held byte moves to the shift stage (tx_byte, tx_byte_valid) only during a target-transmit transfer, one edge after it becomes eligible. An ev_tx_need pulse empties the shift stage, and a waiting held byte refills it at that same edge.
- R7: Received bytes are accepted only during a target-receive transfer. A byte shows on rx_data with flag_rx=1 two edges after its ev_rx_byte pulse. A rd_rx pulse while flag_rx is 1 removes it.
- R8: A byte (or a routed address) that arrives while both receive stages are full and no read frees a stage is dropped, and err_ovf is set. err_ovf stays set until a clr_ovf pulse. A read in the same cycle as an arrival frees room, so no overrun occurs.
- R9: ev_stop returns the transfer tracker to idle. With cfg_tx_on_empty=0, flag_tx is 0 from the next edge until the next target-transmit address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_to_rx | input | 1 | 1: matched address also goes through the receive path |
| cfg_tx_on_empty | input | 1 | 1: request transmit data whenever the holding register is empty |
| ev_addr_match | input | 1 | Engine pulse: own address matched |
| ev_addr_byte | input | DATA_W | Matched address byte, bit 0 = direction |
| ev_rx_byte | input | 1 | Engine pulse: a data byte was received |
| ev_rx_data | input | DATA_W | Received data byte |
| ev_tx_need | input | 1 | Engine pulse: shifter takes the outgoing byte |
| ev_stop | input | 1 | Engine pulse: STOP seen |
| wr_tx | input | 1 | Host write strobe for transmit data |
| wr_data | input | DATA_W | Host write data |
| rd_rx | input | 1 | Host read strobe for receive data |
| rd_addr | input | 1 | Host read strobe for the address status |
| clr_ovf | input | 1 | Write-one-to-clear strobe for err_ovf |
| flag_tx | output | 1 | Transmit data requested |
| flag_rx | output | 1 | Received data ready |
| flag_addr | output | 1 | Address valid |
| err_ovf | output | 1 | Sticky receive overrun |
| rx_data | output | DATA_W | Receive holding register |
| addr_status | output | DATA_W | Last matched address byte |
| tx_byte | output | DATA_W | Byte offered to the shifter |
| tx_byte_valid | output | 1 | tx_byte holds a valid byte |

## Verification
The case that matters is a host read of the receive holding register in the same cycle that the engine delivers a new byte while both receive stages are full. The read must free the holding register, the shift stage must move forward, and the new byte must be taken without an overrun. The bench first fills both stages, provokes and then clears a real overrun, and then pulses rd_rx together with ev_rx_byte. It judges the result by checking that err_ovf stays 0 and by the order in which the bytes come out of rx_data. A second coincidence, where the shifter takes a byte at the same edge that the held byte refills the shift stage, is judged from tx_byte and flag_tx after that edge.

// File: rtl/i2ct_buf_pkg.sv
package i2ct_buf_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        XFER_IDLE = 2'd0,
        XFER_SEND = 2'd1,
        XFER_RECV = 2'd2
    } xfer_e;

    // Bit 0 of the address byte: 1 = controller reads (target sends)
    function automatic xfer_e dir_of(input logic rw_bit);
        return rw_bit ? XFER_SEND : XFER_RECV;
    endfunction

endpackage

// File: rtl/i2ct_xfer_track.sv
module i2ct_xfer_track
    import i2ct_buf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  addr_hit,
    input  logic  addr_rw,
    input  logic  stop_hit,
    output xfer_e xfer
);
    always_ff @(posedge clk) begin
        if (rst) begin
            xfer <= XFER_IDLE;
        end else if (addr_hit) begin
            xfer <= dir_of(addr_rw);
        end else if (stop_hit) begin
            xfer <= XFER_IDLE;
        end
    end
endmodule

// File: rtl/i2ct_tx_path.sv
module i2ct_tx_path
    import i2ct_buf_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_e             xfer,
    input  logic              cfg_on_empty,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              take_stb,
    output logic              req_flag,
    output logic [DATA_W-1:0] sh_byte,
    output logic              sh_valid
);
    logic              hold_full;
    logic [DATA_W-1:0] hold_q;
    logic              sending;
    logic              wr_ok;
    logic              take;
    logic              move;

    assign sending  = (xfer == XFER_SEND);
    assign req_flag = !hold_full && (cfg_on_empty || sending);
    assign wr_ok    = wr_stb && req_flag;
    assign take     = take_stb && sh_valid && sending;
    assign move     = hold_full && sending && (!sh_valid || take);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
        end else if (wr_ok) begin
            hold_full <= 1'b1;
            hold_q    <= wr_val;
        end else if (move) begin
            hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_valid <= 1'b0;
            sh_byte  <= '0;
        end else if (move) begin
            sh_valid <= 1'b1;
            sh_byte  <= hold_q;
        end else if (take) begin
            sh_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/i2ct_rx_path.sv
module i2ct_rx_path
    import i2ct_buf_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_e             xfer,
    input  logic              cfg_addr_rx,
    input  logic              addr_hit,
    input  logic [DATA_W-1:0] addr_byte,
    input  logic              byte_hit,
    input  logic [DATA_W-1:0] byte_val,
    input  logic              rd_data_stb,
    input  logic              rd_addr_stb,
    input  logic              clr_err,
    output logic              data_flag,
    output logic              tag_flag,
    output logic [DATA_W-1:0] hold_byte,
    output logic              err
);
    logic              hold_full, hold_tag;
    logic              sh_full, sh_tag;
    logic [DATA_W-1:0] sh_q;
    logic              push_addr, push_byte, push;
    logic [DATA_W-1:0] push_val;
    logic              pop, move, sh_room, overrun;

    assign push_addr = addr_hit && cfg_addr_rx;
    assign push_byte = byte_hit && !addr_hit && (xfer == XFER_RECV);
    assign push      = push_addr || push_byte;
    assign push_val  = push_addr ? addr_byte : byte_val;

    assign data_flag = hold_full && !hold_tag;
    assign tag_flag  = hold_full && hold_tag;

    assign pop     = (rd_data_stb && (data_flag || (cfg_addr_rx && tag_flag)))
                   || (rd_addr_stb && cfg_addr_rx && tag_flag);
    assign move    = sh_full && (!hold_full || pop);
    assign sh_room = !sh_full || move;
    assign overrun = push && !sh_room;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_tag  <= 1'b0;
            hold_byte <= '0;
        end else if (move) begin
            hold_full <= 1'b1;
            hold_tag  <= sh_tag;
            hold_byte <= sh_q;
        end else if (pop) begin
            hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_full <= 1'b0;
            sh_tag  <= 1'b0;
            sh_q    <= '0;
        end else if (push && sh_room) begin
            sh_full <= 1'b1;
            sh_tag  <= push_addr;
            sh_q    <= push_val;
        end else if (move) begin
            sh_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err <= 1'b0;
        end else if (overrun) begin
            err <= 1'b1;
        end else if (clr_err) begin
            err <= 1'b0;
        end
    end
endmodule

// File: rtl/i2ct_data_buffer.sv
module i2ct_data_buffer
    import i2ct_buf_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_addr_to_rx,
    input  logic              cfg_tx_on_empty,
    input  logic              ev_addr_match,
    input  logic [DATA_W-1:0] ev_addr_byte,
    input  logic              ev_rx_byte,
    input  logic [DATA_W-1:0] ev_rx_data,
    input  logic              ev_tx_need,
    input  logic              ev_stop,
    input  logic              wr_tx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_rx,
    input  logic              rd_addr,
    input  logic              clr_ovf,
    output logic              flag_tx,
    output logic              flag_rx,
    output logic              flag_addr,
    output logic              err_ovf,
    output logic [DATA_W-1:0] rx_data,
    output logic [DATA_W-1:0] addr_status,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_byte_valid
);
    xfer_e xfer;
    logic  addr_valid;
    logic  rx_tag_flag;

    i2ct_xfer_track u_track (
        .clk      (clk),
        .rst      (rst),
        .addr_hit (ev_addr_match),
        .addr_rw  (ev_addr_byte[0]),
        .stop_hit (ev_stop),
        .xfer     (xfer)
    );

    i2ct_tx_path #(.DATA_W(DATA_W)) u_tx (
        .clk          (clk),
        .rst          (rst),
        .xfer         (xfer),
        .cfg_on_empty (cfg_tx_on_empty),
        .wr_stb       (wr_tx),
        .wr_val       (wr_data),
        .take_stb     (ev_tx_need),
        .req_flag     (flag_tx),
        .sh_byte      (tx_byte),
        .sh_valid     (tx_byte_valid)
    );

    i2ct_rx_path #(.DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .xfer        (xfer),
        .cfg_addr_rx (cfg_addr_to_rx),
        .addr_hit    (ev_addr_match),
        .addr_byte   (ev_addr_byte),
        .byte_hit    (ev_rx_byte),
        .byte_val    (ev_rx_data),
        .rd_data_stb (rd_rx),
        .rd_addr_stb (rd_addr),
        .clr_err     (clr_ovf),
        .data_flag   (flag_rx),
        .tag_flag    (rx_tag_flag),
        .hold_byte   (rx_data),
        .err         (err_ovf)
    );

    // Address status register; its own valid bit serves the non-routed mode
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_status <= '0;
            addr_valid  <= 1'b0;
        end else if (ev_addr_match) begin
            addr_status <= ev_addr_byte;
            addr_valid  <= !cfg_addr_to_rx;
        end else if (rd_addr && addr_valid) begin
            addr_valid  <= 1'b0;
        end
    end

    assign flag_addr = cfg_addr_to_rx ? rx_tag_flag : addr_valid;

endmodule

// File: rtl/i2ct_data_buffer_chk.sv
module i2ct_data_buffer_chk
    import i2ct_buf_pkg::*;
#(
    parameter int unsigned DATA_W = BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_addr_to_rx,
    input logic              cfg_tx_on_empty,
    input logic              ev_addr_match,
    input logic [DATA_W-1:0] ev_addr_byte,
    input logic              ev_rx_byte,
    input logic              ev_stop,
    input logic              wr_tx,
    input logic              clr_ovf,
    input logic              flag_tx,
    input logic              flag_rx,
    input logic              flag_addr,
    input logic              err_ovf,
    input logic [DATA_W-1:0] addr_status,
    input logic              tx_byte_valid,
    input xfer_e             xfer
);
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!flag_rx && !flag_addr && !err_ovf && !tx_byte_valid));

    p_addr_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (ev_addr_match && !cfg_addr_to_rx)
            |=> (flag_addr && addr_status == $past(ev_addr_byte)));

    p_write_clears_req_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && flag_tx && $stable(cfg_tx_on_empty)) |=> !flag_tx);

    p_load_in_send_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_byte_valid) |-> $past(xfer == XFER_SEND));

    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err_ovf) |-> $past(ev_rx_byte || ev_addr_match));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (err_ovf && !clr_ovf) |=> err_ovf);

    p_stop_drops_req_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_stop && !ev_addr_match && !cfg_tx_on_empty) |=> !flag_tx);
endmodule

bind i2ct_data_buffer i2ct_data_buffer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_addr_to_rx  (cfg_addr_to_rx),
    .cfg_tx_on_empty (cfg_tx_on_empty),
    .ev_addr_match   (ev_addr_match),
    .ev_addr_byte    (ev_addr_byte),
    .ev_rx_byte      (ev_rx_byte),
    .ev_stop         (ev_stop),
    .wr_tx           (wr_tx),
    .clr_ovf         (clr_ovf),
    .flag_tx         (flag_tx),
    .flag_rx         (flag_rx),
    .flag_addr       (flag_addr),
    .err_ovf         (err_ovf),
    .addr_status     (addr_status),
    .tx_byte_valid   (tx_byte_valid),
    .xfer            (xfer)
);

// File: tb/i2ct_data_buffer_test.sv
`timescale 1ns/1ps
module i2ct_data_buffer_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_addr_to_rx = 1'b0, cfg_tx_on_empty = 1'b0;
    logic         ev_addr_match = 1'b0, ev_rx_byte = 1'b0, ev_tx_need = 1'b0, ev_stop = 1'b0;
    logic [W-1:0] ev_addr_byte = '0, ev_rx_data = '0, wr_data = '0;
    logic         wr_tx = 1'b0, rd_rx = 1'b0, rd_addr = 1'b0, clr_ovf = 1'b0;
    logic         flag_tx, flag_rx, flag_addr, err_ovf, tx_byte_valid;
    logic [W-1:0] rx_data, addr_status, tx_byte;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    i2ct_data_buffer #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst),
        .cfg_addr_to_rx(cfg_addr_to_rx), .cfg_tx_on_empty(cfg_tx_on_empty),
        .ev_addr_match(ev_addr_match), .ev_addr_byte(ev_addr_byte),
        .ev_rx_byte(ev_rx_byte), .ev_rx_data(ev_rx_data),
        .ev_tx_need(ev_tx_need), .ev_stop(ev_stop),
        .wr_tx(wr_tx), .wr_data(wr_data), .rd_rx(rd_rx), .rd_addr(rd_addr),
        .clr_ovf(clr_ovf),
        .flag_tx(flag_tx), .flag_rx(flag_rx), .flag_addr(flag_addr),
        .err_ovf(err_ovf), .rx_data(rx_data), .addr_status(addr_status),
        .tx_byte(tx_byte), .tx_byte_valid(tx_byte_valid)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h (addr_cfg=%0b empty_mode=%0b)",
                     tag, act, exp, cfg_addr_to_rx, cfg_tx_on_empty);
        end
    endtask

    task automatic addr_cycle(input logic [W-1:0] b);
        ev_addr_match = 1'b1; ev_addr_byte = b; tick(); ev_addr_match = 1'b0;
    endtask

    task automatic rx_cycle(input logic [W-1:0] b);
        ev_rx_byte = 1'b1; ev_rx_data = b; tick(); ev_rx_byte = 1'b0;
    endtask

    task automatic wr_cycle(input logic [W-1:0] b);
        wr_tx = 1'b1; wr_data = b; tick(); wr_tx = 1'b0;
    endtask

    task automatic stop_cycle();
        ev_stop = 1'b1; tick(); ev_stop = 1'b0;
    endtask

    // Address was matched one edge ago; wait for it to settle, check, then read it
    task automatic check_and_read_addr(input logic rxc, input logic [W-1:0] b);
        tick();
        chk(rxc ? "R3 flag_addr routed" : "R2 flag_addr set", flag_addr, 1);
        chk("R2 addr_status", addr_status, b);
        if (rxc) begin
            chk("R3 rx_data holds address", rx_data, b);
            chk("R3 flag_rx stays low", flag_rx, 0);
            rd_rx = 1'b1; tick(); rd_rx = 1'b0;
            chk("R3 rd_rx clears flag_addr", flag_addr, 0);
        end else begin
            rd_addr = 1'b1; tick(); rd_addr = 1'b0;
            chk("R2 rd_addr clears flag_addr", flag_addr, 0);
        end
    endtask

    task automatic run_cfg(input logic rxc, input logic txe);
        cfg_addr_to_rx = rxc; cfg_tx_on_empty = txe;
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        chk("R1 flag_rx", flag_rx, 0);
        chk("R1 flag_addr", flag_addr, 0);
        chk("R1 err_ovf", err_ovf, 0);
        chk("R1 tx_byte_valid", tx_byte_valid, 0);
        chk("R1 flag_tx", flag_tx, txe);

        // ---------------- transmit side ----------------
        chk("R4 idle request", flag_tx, txe);
        wr_cycle(8'hA5);
        chk("R5 flag_tx after write", flag_tx, 0);
        tick();
        chk("R6 no load while idle", tx_byte_valid, 0);
        addr_cycle(8'h75);                       // bit0=1: target transmit
        chk("R6 no load at address edge", tx_byte_valid, 0);
        tick();
        chk("R6 load during send", tx_byte_valid, txe);
        if (txe) chk("R6 tx_byte first", tx_byte, 8'hA5);
        chk("R4 request in send", flag_tx, 1);
        // address flag has now had two edges
        chk(rxc ? "R3 flag_addr routed" : "R2 flag_addr set", flag_addr, 1);
        chk("R2 addr_status", addr_status, 8'h75);
        if (rxc) begin
            chk("R3 rx_data holds address", rx_data, 8'h75);
            chk("R3 flag_rx stays low", flag_rx, 0);
            rd_rx = 1'b1; tick(); rd_rx = 1'b0;
        end else begin
            rd_addr = 1'b1; tick(); rd_addr = 1'b0;
        end
        chk("R2 R3 address read clears flag", flag_addr, 0);

        wr_cycle(8'hB1);
        chk("R5 write clears request", flag_tx, 0);
        tick();
        if (txe) begin
            chk("R6 shift keeps first byte", tx_byte, 8'hA5);
            chk("R6 hold waits", flag_tx, 0);
        end else begin
            chk("R6 valid after move", tx_byte_valid, 1);
            chk("R6 tx_byte moved", tx_byte, 8'hB1);
            chk("R4 request after move", flag_tx, 1);
        end
        ev_tx_need = 1'b1; tick(); ev_tx_need = 1'b0;
        if (txe) begin
            chk("R6 refill at take edge", tx_byte_valid, 1);
            chk("R6 refilled byte", tx_byte, 8'hB1);
        end else begin
            chk("R6 take empties shift", tx_byte_valid, 0);
        end
        chk("R4 request after take", flag_tx, 1);

        stop_cycle();
        chk("R9 request after stop", flag_tx, txe);
        wr_cycle(8'hC3);                          // ignored when txe=0
        chk("R5 flag after late write", flag_tx, 0);
        addr_cycle(8'h75);
        tick();
        chk("R5 R9 request on new send", flag_tx, !txe);
        if (rxc) begin
            rd_rx = 1'b1; tick(); rd_rx = 1'b0;
        end else begin
            rd_addr = 1'b1; tick(); rd_addr = 1'b0;
        end
        stop_cycle();

        // ---------------- receive side ----------------
        rx_cycle(8'h55);
        tick();
        chk("R7 byte ignored while idle", flag_rx, 0);
        addr_cycle(8'h74);                        // bit0=0: target receive
        check_and_read_addr(rxc, 8'h74);

        rx_cycle(8'h61);
        chk("R7 not visible after one edge", flag_rx, 0);
        tick();
        chk("R7 flag_rx after two edges", flag_rx, 1);
        chk("R7 rx_data first", rx_data, 8'h61);
        rx_cycle(8'h62);
        rx_cycle(8'h63);
        chk("R8 overrun sets err", err_ovf, 1);
        chk("R8 holding kept", rx_data, 8'h61);
        tick();
        chk("R8 err sticky", err_ovf, 1);
        clr_ovf = 1'b1; tick(); clr_ovf = 1'b0;
        chk("R8 clear by write-one", err_ovf, 0);
        rd_rx = 1'b1; ev_rx_byte = 1'b1; ev_rx_data = 8'h64;
        tick();
        rd_rx = 1'b0; ev_rx_byte = 1'b0;
        chk("R8 read with arrival no overrun", err_ovf, 0);
        chk("R7 second byte forwarded", rx_data, 8'h62);
        chk("R7 flag_rx kept", flag_rx, 1);
        rd_rx = 1'b1; tick(); rd_rx = 1'b0;
        chk("R8 dropped byte skipped", rx_data, 8'h64);
        chk("R7 flag_rx for last", flag_rx, 1);
        rd_rx = 1'b1; tick(); rd_rx = 1'b0;
        chk("R7 read empties", flag_rx, 0);
        stop_cycle();
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        tick();
        for (int c = 0; c < 4; c++) begin
            run_cfg(c[1], c[0]);
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule